// File: doc/BRIEF.md
# Bus Source Handshake Controller

This block is the talker side of a three-wire byte handshake on an IEEE-488 style instrument bus. It raises the data-valid line (DAV) only after the listeners report ready-for-data (RFD) and a settling delay has passed. It keeps DAV up until they report data-accepted (DAC), and then starts the next byte. A set of source states sequences these steps.

Towards the instrument it uses a two-wire handshake. The `dcd_o` output (don't change data) is low only while the block waits for a new byte. The `nba_i` input is low while the device holds a new byte ready. With `dcd_o` wired straight back to `nba_i`, the block moves a byte on every pass with no help from the device.

The source runs while the device is a talker and attention (ATN) is false. A controller-active input (`cats_i`) overrides that and pulls the source out of its idle states. A separate output flags the take-control message while the acceptor sits in its accepted-data state. Inputs are captured on the falling clock edge and all state changes on the rising edge.

Top module: `src_handshake_ctrl`

## Requirements
- R1: After reset and while reset is held, `dav_o`, `dcd_o` and `tct_o` are low and the source is in its idle state.
- R2: The source leaves idle for the generate state when `talker_i` is high and `atn_i` is low, or when `cats_i` is high. With `cats_i` low and no talker addressing, the source stays idle.
- R3: In generate, `dcd_o` is low. A low `nba_i` moves the source to the delay state, where `dcd_o` goes high. `dcd_o` stays high in the delay, transfer, wait and idle-wait states.
- R4: `dav_o` rises only after the source has been in the delay state for at least `SETTLE_CYC` clocks and the last of those clocks saw `rfd_i` high.
- R5: `dav_o` stays high until `dac_i` is seen high, and then drops. If `nba_i` is then high, the source goes straight to generate. Otherwise it goes to the wait state, which moves to generate once `nba_i` is high.
- R6: When the source becomes inactive (`atn_i` high or `talker_i` low, with `cats_i` low), two things can happen. From generate it returns to idle. From delay, transfer or wait it enters idle-wait with `dav_o` low and `dcd_o` high.
- R7: Idle-wait moves to the wait state when the source becomes active again (including through `cats_i`). While the source stays inactive, idle-wait moves to idle (`dcd_o` low) once `nba_i` is high.
- R8: `tct_o` is high exactly one clock after a falling-edge sample saw both `tct_msg_i` and `acc_done_i` high.
- R9: Inputs are taken on the falling clock edge. A change made after a falling edge does not reach the outputs at the next rising edge, only at the one after.
- R10: With `dcd_o` looped back to `nba_i` and `rfd_i` and `dac_i` held high, the source moves one byte every `SETTLE_CYC`+2 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; inputs captured on the falling edge, state on the rising edge |
| rst_i | input | 1 | Synchronous active-high reset to the initial state |
| talker_i | input | 1 | Device addressed as talker or in talk-only mode |
| atn_i | input | 1 | Bus attention, positive logic |
| cats_i | input | 1 | Controller active override; tie low when unused |
| rfd_i | input | 1 | Listeners ready for data, positive logic |
| dac_i | input | 1 | Listeners have accepted the data, positive logic |
| nba_i | input | 1 | Low while the device offers a new byte |
| tct_msg_i | input | 1 | Take-control message present on the bus |
| acc_done_i | input | 1 | Acceptor in its accepted-data state |
| dav_o | output | 1 | Data valid to the bus, positive logic |
| dcd_o | output | 1 | High: device must hold its data byte |
| tct_o | output | 1 | Take-control indication |

## Verification
A source stuck in a wrong state shows at the ports within one or two clocks. It may raise `dav_o` too early or keep it high after DAC. It may hold `dcd_o` high in idle, or fail to drop `dcd_o` when the device withdraws its byte. Idle and generate look the same at the ports, so the stimulus table follows each entry into generate with a low `nba_i`; the next clock must then show `dcd_o` high. The looped-back run counts DAV pulses over a fixed window, so a wrong settling count changes the total.

// File: rtl/src_hs_pkg.sv
package src_hs_pkg;

    typedef enum logic [2:0] {
        SRC_IDLE  = 3'd0,
        SRC_GEN   = 3'd1,
        SRC_DLY   = 3'd2,
        SRC_XFER  = 3'd3,
        SRC_WAIT  = 3'd4,
        SRC_IWAIT = 3'd5
    } src_state_e;

    typedef struct packed {
        logic talker;
        logic atn;
        logic cats;
        logic rfd;
        logic dac;
        logic nba;
        logic tct_msg;
        logic acc_done;
    } hs_in_t;

    localparam int HS_IN_W = $bits(hs_in_t);

endpackage

// File: rtl/src_hs_sampler.sv
module src_hs_sampler
    import src_hs_pkg::*;
#(
    parameter hs_in_t RST_VAL = '0
) (
    input  logic   clk_i,
    input  logic   rst_i,
    input  hs_in_t raw_i,
    output hs_in_t smp_o
);

    hs_in_t smp_d, smp_q;

    always_comb begin
        smp_d = raw_i;
        if (rst_i) begin
            smp_d = RST_VAL;
        end
    end

    // capture on the falling edge; the source state uses it on the rising edge
    always_ff @(negedge clk_i) begin
        smp_q <= smp_d;
    end

    assign smp_o = smp_q;

endmodule

// File: rtl/src_hs_fsm.sv
module src_hs_fsm
    import src_hs_pkg::*;
#(
    parameter int SETTLE_CYC = 2
) (
    input  logic   clk_i,
    input  logic   rst_i,
    input  hs_in_t smp_i,
    output logic   dav_o,
    output logic   dcd_o
);

    localparam int CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        src_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             dav;
        logic             dcd;
    } fsm_t;

    fsm_t r_q, r_d;
    logic active;

    always_comb begin
        r_d    = r_q;
        active = (smp_i.talker & ~smp_i.atn) | smp_i.cats;

        unique case (r_q.st)
            SRC_IDLE: begin
                if (active) r_d.st = SRC_GEN;
            end
            SRC_GEN: begin
                if (!active)         r_d.st = SRC_IDLE;
                else if (!smp_i.nba) r_d.st = SRC_DLY;
            end
            SRC_DLY: begin
                if (!active)                           r_d.st = SRC_IWAIT;
                else if (smp_i.rfd && r_q.cnt >= CNT_LIM) r_d.st = SRC_XFER;
            end
            SRC_XFER: begin
                if (!active)        r_d.st = SRC_IWAIT;
                else if (smp_i.dac) r_d.st = smp_i.nba ? SRC_GEN : SRC_WAIT;
            end
            SRC_WAIT: begin
                if (!active)        r_d.st = SRC_IWAIT;
                else if (smp_i.nba) r_d.st = SRC_GEN;
            end
            SRC_IWAIT: begin
                if (active)         r_d.st = SRC_WAIT;
                else if (smp_i.nba) r_d.st = SRC_IDLE;
            end
            default: r_d.st = SRC_IDLE;
        endcase

        // settling counter runs only while the source stays in delay
        if (r_q.st == SRC_DLY && r_d.st == SRC_DLY) begin
            r_d.cnt = (r_q.cnt == CNT_MAX) ? r_q.cnt : r_q.cnt + 1'b1;
        end else begin
            r_d.cnt = '0;
        end

        r_d.dav = (r_d.st == SRC_XFER);
        r_d.dcd = (r_d.st == SRC_DLY) || (r_d.st == SRC_XFER) ||
                  (r_d.st == SRC_WAIT) || (r_d.st == SRC_IWAIT);

        if (rst_i) begin
            r_d = '{st: SRC_IDLE, cnt: '0, dav: 1'b0, dcd: 1'b0};
        end
    end

    always_ff @(posedge clk_i) begin
        r_q <= r_d;
    end

    assign dav_o = r_q.dav;
    assign dcd_o = r_q.dcd;

endmodule

// File: rtl/src_hs_tct.sv
module src_hs_tct (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tct_msg_i,
    input  logic acc_done_i,
    output logic tct_o
);

    logic tct_d, tct_q;

    always_comb begin
        tct_d = tct_msg_i & acc_done_i;
        if (rst_i) tct_d = 1'b0;
    end

    always_ff @(posedge clk_i) begin
        tct_q <= tct_d;
    end

    assign tct_o = tct_q;

endmodule

// File: rtl/src_handshake_ctrl.sv
module src_handshake_ctrl
    import src_hs_pkg::*;
#(
    parameter int SETTLE_CYC = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic talker_i,
    input  logic atn_i,
    input  logic cats_i,
    input  logic rfd_i,
    input  logic dac_i,
    input  logic nba_i,
    input  logic tct_msg_i,
    input  logic acc_done_i,
    output logic dav_o,
    output logic dcd_o,
    output logic tct_o
);

    localparam hs_in_t SMP_RST = '{talker: 1'b0, atn: 1'b0, cats: 1'b0, rfd: 1'b0,
                                   dac: 1'b0, nba: 1'b1, tct_msg: 1'b0, acc_done: 1'b0};

    hs_in_t raw, smp;

    assign raw = '{talker: talker_i, atn: atn_i, cats: cats_i, rfd: rfd_i,
                   dac: dac_i, nba: nba_i, tct_msg: tct_msg_i, acc_done: acc_done_i};

    src_hs_sampler #(.RST_VAL(SMP_RST)) u_smp (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .raw_i (raw),
        .smp_o (smp)
    );

    src_hs_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .smp_i (smp),
        .dav_o (dav_o),
        .dcd_o (dcd_o)
    );

    src_hs_tct u_tct (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .tct_msg_i  (smp.tct_msg),
        .acc_done_i (smp.acc_done),
        .tct_o      (tct_o)
    );

endmodule

// File: rtl/src_handshake_ctrl_chk.sv
module src_handshake_ctrl_chk (
    input logic clk_i,
    input logic rst_i,
    input logic dav_o,
    input logic dcd_o,
    input logic tct_o,
    input logic s_talker,
    input logic s_atn,
    input logic s_cats,
    input logic s_rfd,
    input logic s_dac,
    input logic s_tct,
    input logic s_acc
);

    logic on_bus;
    assign on_bus = (s_talker && !s_atn) || s_cats;

    // R1: just out of reset the outputs are quiet
    assert_reset_quiet_R1: assert property (@(posedge clk_i)
        $fell(rst_i) |-> (!dav_o && !dcd_o && !tct_o));

    // R3: data is never valid while the device may change it
    assert_dav_holds_dcd_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        dav_o |-> dcd_o);

    // R4: a DAV edge needs ready-for-data and a prior delay cycle
    assert_dav_rise_rfd_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(dav_o) |-> ($past(s_rfd) && $past(dcd_o)));

    // R5: DAV is held until accepted
    assert_dav_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (dav_o && !s_dac && on_bus) |=> dav_o);

    // R5: DAV drops once accepted
    assert_dav_drop_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (dav_o && s_dac) |=> !dav_o);

    // R6: losing the bus drops DAV
    assert_dav_abort_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (dav_o && !on_bus) |=> !dav_o);

    // R6: an inactive source with dcd low stays with dcd low
    assert_idle_stays_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!on_bus && !dcd_o) |=> !dcd_o);

    // R8: take-control follows the sampled message and accepted state
    assert_tct_set_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (s_tct && s_acc) |=> tct_o);

    assert_tct_clr_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        !(s_tct && s_acc) |=> !tct_o);

endmodule

bind src_handshake_ctrl src_handshake_ctrl_chk u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .dav_o    (dav_o),
    .dcd_o    (dcd_o),
    .tct_o    (tct_o),
    .s_talker (smp.talker),
    .s_atn    (smp.atn),
    .s_cats   (smp.cats),
    .s_rfd    (smp.rfd),
    .s_dac    (smp.dac),
    .s_tct    (smp.tct_msg),
    .s_acc    (smp.acc_done)
);

// File: tb/src_handshake_ctrl_test.sv
module src_handshake_ctrl_test;

    localparam int SETTLE = 2;
    localparam int NVEC   = 27;

    logic clk = 1'b0;
    logic rst;
    logic talker, atn, cats, rfd, dac, nba_drv, tct_msg, acc;
    logic loopback;
    logic nba;
    logic dav, dcd, tct;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    assign nba = loopback ? dcd : nba_drv;

    src_handshake_ctrl #(.SETTLE_CYC(SETTLE)) uut (
        .clk_i      (clk),
        .rst_i      (rst),
        .talker_i   (talker),
        .atn_i      (atn),
        .cats_i     (cats),
        .rfd_i      (rfd),
        .dac_i      (dac),
        .nba_i      (nba),
        .tct_msg_i  (tct_msg),
        .acc_done_i (acc),
        .dav_o      (dav),
        .dcd_o      (dcd),
        .tct_o      (tct)
    );

    // {talker atn cats rfd dac nba tct acc} , expected {dav dcd tct} one clock later
    localparam logic [10:0] VEC [NVEC] = '{
        {8'b0000_0100, 3'b000},  //  0 R2 no addressing, stay idle
        {8'b1000_0100, 3'b000},  //  1 R2 idle -> generate
        {8'b1000_0100, 3'b000},  //  2 R3 generate waits for byte
        {8'b1000_0000, 3'b010},  //  3 R3 byte ready -> delay
        {8'b1000_0000, 3'b010},  //  4 R4 no rfd, keep delay
        {8'b1001_0000, 3'b110},  //  5 R4 rfd and settled -> DAV
        {8'b1001_0000, 3'b110},  //  6 R5 hold without DAC
        {8'b1001_1000, 3'b010},  //  7 R5 DAC, byte still flagged -> wait
        {8'b1001_1000, 3'b010},  //  8 R5 wait holds
        {8'b1001_1100, 3'b000},  //  9 R5 nba high -> generate
        {8'b1001_0000, 3'b010},  // 10 R3 -> delay
        {8'b1001_0000, 3'b010},  // 11 R4 rfd early, still settling
        {8'b1001_0000, 3'b110},  // 12 R4 DAV after full delay
        {8'b1001_1100, 3'b000},  // 13 R5 DAC with nba high -> generate
        {8'b1100_0000, 3'b000},  // 14 R6 ATN in generate -> idle
        {8'b1110_0000, 3'b000},  // 15 R2 cats leaves idle
        {8'b1110_0000, 3'b010},  // 16 R3 generate -> delay under cats
        {8'b1111_0000, 3'b010},  // 17 R4 settling
        {8'b1111_0000, 3'b110},  // 18 R4 DAV under cats
        {8'b1101_0000, 3'b010},  // 19 R6 cats drops in transfer -> idle-wait
        {8'b1100_0000, 3'b010},  // 20 R7 idle-wait holds while nba low
        {8'b1110_0000, 3'b010},  // 21 R7 cats -> wait
        {8'b1110_0100, 3'b000},  // 22 R7 wait -> generate confirms wait state
        {8'b0000_0100, 3'b000},  // 23 R6 generate -> idle
        {8'b0000_0111, 3'b001},  // 24 R8 tct and accepted
        {8'b0000_0110, 3'b000},  // 25 R8 tct without accepted
        {8'b0000_0101, 3'b000}   // 26 R8 accepted without tct
    };

    function automatic string vec_req(input int i);
        case (i)
            0, 1, 15:                 return "R2";
            2, 3, 10, 16:             return "R3";
            4, 5, 11, 12, 17, 18:     return "R4";
            6, 7, 8, 9, 13:           return "R5";
            14, 19, 23:               return "R6";
            20, 21, 22:               return "R7";
            default:                  return "R8";
        endcase
    endfunction

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic drive(input logic [7:0] v);
        {talker, atn, cats, rfd, dac, nba_drv, tct_msg, acc} = v;
    endtask

    task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: {dav,dcd,tct} actual %b expected %b", req, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int dav_cnt;
        loopback = 1'b0;
        rst = 1'b1;
        drive(8'b0000_0100);
        step(); step(); step();
        check("R1", {dav, dcd, tct}, 3'b000);   // R1 reset state
        rst = 1'b0;
        step();
        check("R1", {dav, dcd, tct}, 3'b000);

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][10:3]);
            step();
            check(vec_req(i), {dav, dcd, tct}, VEC[i][2:0]);
        end

        // R9: change after the falling edge is seen one rising edge late
        drive(8'b0000_0100);
        step();
        #5;
        tct_msg = 1'b1;
        acc     = 1'b1;
        step();
        check("R9", {dav, dcd, tct}, 3'b000);
        step();
        check("R9", {dav, dcd, tct}, 3'b001);

        // R1: reset in the middle of a transfer
        drive(8'b1001_0000);
        step(); step(); step(); step(); step();
        check("R1", {dav, dcd, tct}, 3'b110);
        rst = 1'b1;
        step();
        check("R1", {dav, dcd, tct}, 3'b000);
        rst = 1'b0;
        drive(8'b0000_0100);
        step();
        check("R1", {dav, dcd, tct}, 3'b000);

        // R10: dcd looped to nba, one byte every SETTLE+2 clocks
        loopback = 1'b1;
        drive(8'b1001_1100);
        step();                      // idle -> generate
        dav_cnt = 0;
        for (int k = 0; k < 20; k++) begin
            step();
            if (dav) dav_cnt++;
        end
        n_chk++;
        if (dav_cnt != 20 / (SETTLE + 2)) begin
            n_fail++;
            $display("FAIL R10: DAV pulses actual %0d expected %0d", dav_cnt, 20 / (SETTLE + 2));
        end

        finish_run();
    end

endmodule